// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block is one DMA channel that copies a run of 32-bit words between main memory and a peripheral data port. Software sets it up through three registers: a byte address, a block-shape register and a control register. A control write with the busy bit set starts the transfer. The exact control word chooses the direction: memory to peripheral, or peripheral to memory.

The total word count is the product of the two 16-bit halves of the block-shape register. The engine makes one memory access per word and uses a valid/ready handshake on the peripheral side for every word. After each word it adds four to the address register, so at the end the register points just past the last word moved. When the transfer ends, the busy bit clears and a one-cycle done pulse is raised in the same cycle.

A control word with the busy bit set that matches neither direction moves no data. It still clears the busy bit and pulses done. A zero-length block behaves the same way.

Top module: `dma_block_engine`

## Requirements
- R1: After reset, all three registers read zero, `done_o` is low, and no memory request, push or pop is active.
- R2: A write with `cfg_wr_i` high loads the register chosen by `cfg_sel_i`. Select 0 loads the address register, 1 the block-shape register and 2 the control register. Select 3 writes nothing.
- R3: A control write with bit 24 set starts a transfer of `blk[31:16] * blk[15:0]` words. A control write with bit 24 clear only stores the value and starts nothing.
- R4: The control value 0x01000201 moves words from memory to the peripheral. Each word is read from the current address and then held on `push_data_o` with `push_valid_o` high until `push_ready_i` accepts it.
- R5: The control value 0x01000200 moves words from the peripheral to memory. Each word is taken when `pop_valid_i` and `pop_ready_o` are both high, then written to memory at the current address.
- R6: When a transfer ends, the address register holds the start address plus 4 times the number of words moved. Each memory request holds its address until `mem_ack_i` is high.
- R7: Bit 24 of the control register drops in the same cycle that `done_o` is high for exactly one cycle. All other control bits keep their written value.
- R8: A control write with bit 24 set whose value is neither 0x01000201 nor 0x01000200 makes no memory request and no peripheral handshake, and leaves the address unchanged. Busy then clears and done pulses.
- R9: A block-shape product of zero completes with no memory request and an unchanged address.
- R10: While bit 24 of the control register is set, register writes are ignored. This includes a write presented in the cycle in which the transfer finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select (0 address, 1 block shape, 2 control) |
| cfg_wdata_i | input | 32 | Register write data |
| addr_reg_o | output | 32 | Address register contents |
| blk_reg_o | output | 32 | Block-shape register contents |
| ctrl_reg_o | output | 32 | Control register contents (bit 24 = busy) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory accepted the access; read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| push_valid_o | output | 1 | Word offered to the peripheral |
| push_data_o | output | 32 | Word to the peripheral |
| push_ready_i | input | 1 | Peripheral accepts the offered word |
| pop_valid_i | input | 1 | Peripheral offers a word |
| pop_data_i | input | 32 | Word from the peripheral |
| pop_ready_o | output | 1 | Engine takes the offered word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The two events that can land in the same cycle are a register write from software and the handshake that completes the last word. The bench turns every stall off and watches for the final push. In that same cycle it presents a write of a new block shape. It then checks three things: the write was dropped, `done_o` fired together with the busy bit clearing, and a new transfer can be started on the very next write.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
    localparam int REG_W     = 32;
    localparam int HALF_W    = REG_W / 2;
    localparam int BUSY_BIT  = 24;
    localparam int STEP      = REG_W / 8;
    localparam logic [REG_W-1:0] CTRL_TO_PERIPH = 32'h0100_0201;
    localparam logic [REG_W-1:0] CTRL_TO_MEM    = 32'h0100_0200;
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_BLK  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_PUSH, ST_POP, ST_STORE, ST_FIN
    } state_e;

    typedef enum logic [1:0] {
        MODE_NONE, MODE_M2P, MODE_P2M
    } mode_e;

    typedef struct packed {
        state_e            st;
        logic [REG_W-1:0]  addr;
        logic [REG_W-1:0]  blk;
        logic [REG_W-1:0]  ctrl;
        logic [REG_W-1:0]  word;
        logic [REG_W-1:0]  remain;
        logic              done;
    } eng_regs_t;
endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc
    import dma_blk_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic [2*HW-1:0] shape_i,
    output logic [2*HW-1:0] words_o,
    output logic            empty_o
);
    logic [HW-1:0] count_hi;
    logic [HW-1:0] count_lo;

    always_comb begin
        count_hi = shape_i[2*HW-1:HW];
        count_lo = shape_i[HW-1:0];
        words_o  = count_hi * count_lo;
        empty_o  = (count_hi == '0) || (count_lo == '0);
    end
endmodule

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
    import dma_blk_pkg::*;
(
    input  logic [REG_W-1:0] ctrl_i,
    output mode_e            mode_o
);
    always_comb begin
        if (ctrl_i == CTRL_TO_PERIPH)
            mode_o = MODE_M2P;
        else if (ctrl_i == CTRL_TO_MEM)
            mode_o = MODE_P2M;
        else
            mode_o = MODE_NONE;
    end
endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
    import dma_blk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [REG_W-1:0]  addr_reg_o,
    output logic [REG_W-1:0]  blk_reg_o,
    output logic [REG_W-1:0]  ctrl_reg_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [REG_W-1:0]  mem_addr_o,
    output logic [REG_W-1:0]  mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [REG_W-1:0]  mem_rdata_i,
    output logic              push_valid_o,
    output logic [REG_W-1:0]  push_data_o,
    input  logic              push_ready_i,
    input  logic              pop_valid_i,
    input  logic [REG_W-1:0]  pop_data_i,
    output logic              pop_ready_o,
    output logic              done_o
);
    eng_regs_t        r_q;
    eng_regs_t        r_d;
    logic [REG_W-1:0] len_words;
    logic             len_empty;
    mode_e            wr_mode;

    dma_len_calc #(.HW(HALF_W)) u_len (
        .shape_i (r_q.blk),
        .words_o (len_words),
        .empty_o (len_empty)
    );

    dma_mode_decode u_dec (
        .ctrl_i (cfg_wdata_i),
        .mode_o (wr_mode)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = r_q.addr;
        mem_wdata_o  = r_q.word;
        push_valid_o = 1'b0;
        push_data_o  = r_q.word;
        pop_ready_o  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (cfg_wr_i) begin
                    case (cfg_sel_i)
                        SEL_ADDR: r_d.addr = cfg_wdata_i;
                        SEL_BLK:  r_d.blk  = cfg_wdata_i;
                        SEL_CTRL: begin
                            r_d.ctrl = cfg_wdata_i;
                            if (cfg_wdata_i[BUSY_BIT]) begin
                                r_d.remain = len_words;
                                if (len_empty || wr_mode == MODE_NONE)
                                    r_d.st = ST_FIN;
                                else if (wr_mode == MODE_M2P)
                                    r_d.st = ST_FETCH;
                                else
                                    r_d.st = ST_POP;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_FETCH: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    r_d.word = mem_rdata_i;
                    r_d.st   = ST_PUSH;
                end
            end
            ST_PUSH: begin
                push_valid_o = 1'b1;
                if (push_ready_i) begin
                    r_d.addr   = r_q.addr + REG_W'(STEP);
                    r_d.remain = r_q.remain - 1'b1;
                    if (r_q.remain == REG_W'(1)) begin
                        r_d.ctrl[BUSY_BIT] = 1'b0;
                        r_d.done           = 1'b1;
                        r_d.st             = ST_IDLE;
                    end else begin
                        r_d.st = ST_FETCH;
                    end
                end
            end
            ST_POP: begin
                pop_ready_o = 1'b1;
                if (pop_valid_i) begin
                    r_d.word = pop_data_i;
                    r_d.st   = ST_STORE;
                end
            end
            ST_STORE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ack_i) begin
                    r_d.addr   = r_q.addr + REG_W'(STEP);
                    r_d.remain = r_q.remain - 1'b1;
                    if (r_q.remain == REG_W'(1)) begin
                        r_d.ctrl[BUSY_BIT] = 1'b0;
                        r_d.done           = 1'b1;
                        r_d.st             = ST_IDLE;
                    end else begin
                        r_d.st = ST_POP;
                    end
                end
            end
            ST_FIN: begin
                r_d.ctrl[BUSY_BIT] = 1'b0;
                r_d.done           = 1'b1;
                r_d.st             = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_reg_o = r_q.addr;
    assign blk_reg_o  = r_q.blk;
    assign ctrl_reg_o = r_q.ctrl;
    assign done_o     = r_q.done;
endmodule

// File: rtl/dma_block_engine_chk.sv
module dma_block_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_i,
    input logic [1:0]  cfg_sel_i,
    input logic [31:0] addr_reg_o,
    input logic [31:0] blk_reg_o,
    input logic [31:0] ctrl_reg_o,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic        push_valid_o,
    input logic [31:0] push_data_o,
    input logic        push_ready_i,
    input logic        pop_ready_o,
    input logic        done_o
);
    // R7
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_reg_o[24]) |-> done_o);

    // R7
    done_busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ctrl_reg_o[24] && !$past(done_o)));

    // R8
    req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o || push_valid_o || pop_ready_o) |-> ctrl_reg_o[24]);

    // R4
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_data_o)));

    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R10
    busy_blk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reg_o[24] |=> $stable(blk_reg_o));

    // R5
    no_push_pop_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_valid_o && pop_ready_o));
endmodule

bind dma_block_engine dma_block_engine_chk u_chk (.*);

// File: tb/dma_block_engine_test.sv
`timescale 1ns/1ps
module dma_block_engine_test;
    localparam time PERIOD = 5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [1:0]  cfg_sel_i = 2'd3;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] addr_reg_o, blk_reg_o, ctrl_reg_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ack_i;
    logic [31:0] mem_rdata_i;
    logic        push_valid_o;
    logic [31:0] push_data_o;
    logic        push_ready_i;
    logic        pop_valid_i;
    logic [31:0] pop_data_i;
    logic        pop_ready_o;
    logic        done_o;

    int cyc = 0;
    int m_mod = 1, p_mod = 1, q_mod = 1;
    logic [31:0] mem [64];
    logic [31:0] sink [64];
    logic [31:0] src [64];
    int sink_cnt = 0, src_idx = 0, done_cnt = 0, req_cnt = 0, hs_cnt = 0;
    int checks = 0, fails = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_block_engine uut (.*);

    assign mem_ack_i    = mem_req_o && ((cyc % m_mod) == 0);
    assign mem_rdata_i  = mem[mem_addr_o[7:2]];
    assign push_ready_i = ((cyc % p_mod) == 0);
    assign pop_valid_i  = ((cyc % q_mod) == 0);
    assign pop_data_i   = src[src_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done_o) done_cnt <= done_cnt + 1;
        if (mem_req_o) req_cnt <= req_cnt + 1;
        if ((push_valid_o && push_ready_i) || (pop_valid_i && pop_ready_o)) hs_cnt <= hs_cnt + 1;
        if (push_valid_o && push_ready_i) begin
            sink[sink_cnt] <= push_data_o;
            sink_cnt <= sink_cnt + 1;
        end
        if (pop_valid_i && pop_ready_o) src_idx <= src_idx + 1;
        if (mem_req_o && mem_we_o && mem_ack_i) mem[mem_addr_o[7:2]] <= mem_wdata_o;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        sink_cnt = 0; src_idx = 0; done_cnt = 0; req_cnt = 0; hs_cnt = 0;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_sel_i = 2'd3;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (ctrl_reg_o[24] && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(!ctrl_reg_o[24], tag, ctrl_reg_o, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        check(addr_reg_o == 0 && blk_reg_o == 0 && ctrl_reg_o == 0, "R1 regs", ctrl_reg_o, 0);
        check(!done_o && !mem_req_o && !push_valid_o && !pop_ready_o, "R1 outputs",
              {28'h0, done_o, mem_req_o, push_valid_o, pop_ready_o}, 0);
    endtask

    task automatic test_regs_no_start();
        clear_counts();
        wr_reg(2'd0, 32'h0000_0044);
        wr_reg(2'd1, 32'h0002_0002);
        wr_reg(2'd3, 32'hDEAD_BEEF);
        wr_reg(2'd2, 32'h0000_0201);
        repeat (4) @(negedge clk);
        check(addr_reg_o == 32'h44, "R2 addr select 0", addr_reg_o, 32'h44);
        check(blk_reg_o == 32'h0002_0002, "R2 blk select 1 / select 3 inert", blk_reg_o, 32'h0002_0002);
        check(ctrl_reg_o == 32'h201 && req_cnt == 0 && done_cnt == 0, "R3 no start without bit24",
              ctrl_reg_o, 32'h201);
    endtask

    task automatic test_m2p(input logic [31:0] a, input logic [31:0] shape, input int mm, input int pm);
        int n = int'(shape[31:16]) * int'(shape[15:0]);
        m_mod = mm; p_mod = pm;
        clear_counts();
        wr_reg(2'd0, a);
        wr_reg(2'd1, shape);
        wr_reg(2'd2, 32'h0100_0201);
        wait_idle("R7 busy cleared m2p");
        check(sink_cnt == n, "R3 word count m2p", sink_cnt, n);
        for (int i = 0; i < n; i++)
            check(sink[i] == mem[a[7:2] + i], "R4 pushed word", sink[i], mem[a[7:2] + i]);
        check(addr_reg_o == a + 4 * n, "R6 final address m2p", addr_reg_o, a + 4 * n);
        check(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
        check(ctrl_reg_o == 32'h0000_0201, "R7 other ctrl bits kept", ctrl_reg_o, 32'h201);
        m_mod = 1; p_mod = 1;
    endtask

    task automatic test_p2m(input logic [31:0] a, input logic [31:0] shape, input int mm, input int qm);
        int n = int'(shape[31:16]) * int'(shape[15:0]);
        m_mod = mm; q_mod = qm;
        clear_counts();
        for (int i = 0; i < 64; i++) src[i] = 32'h5A00_0000 + i * 32'h111;
        wr_reg(2'd0, a);
        wr_reg(2'd1, shape);
        wr_reg(2'd2, 32'h0100_0200);
        wait_idle("R7 busy cleared p2m");
        for (int i = 0; i < n; i++)
            check(mem[a[7:2] + i] == src[i], "R5 stored word", mem[a[7:2] + i], src[i]);
        check(addr_reg_o == a + 4 * n, "R6 final address p2m", addr_reg_o, a + 4 * n);
        check(done_cnt == 1, "R7 done pulse p2m", done_cnt, 1);
        m_mod = 1; q_mod = 1;
    endtask

    task automatic test_unknown();
        clear_counts();
        wr_reg(2'd0, 32'h0000_0020);
        wr_reg(2'd1, 32'h0001_0004);
        wr_reg(2'd2, 32'h0100_0202);
        wait_idle("R8 busy cleared");
        check(req_cnt == 0 && hs_cnt == 0, "R8 no movement", req_cnt + hs_cnt, 0);
        check(addr_reg_o == 32'h20, "R8 address unchanged", addr_reg_o, 32'h20);
        check(done_cnt == 1 && ctrl_reg_o == 32'h0000_0202, "R8 done and ctrl", ctrl_reg_o, 32'h202);
    endtask

    task automatic test_zero();
        clear_counts();
        wr_reg(2'd0, 32'h0000_0030);
        wr_reg(2'd1, 32'h0000_0007);
        wr_reg(2'd2, 32'h0100_0201);
        wait_idle("R9 busy cleared");
        check(req_cnt == 0 && sink_cnt == 0, "R9 no access", req_cnt, 0);
        check(addr_reg_o == 32'h30 && done_cnt == 1, "R9 address and done", addr_reg_o, 32'h30);
    endtask

    task automatic test_write_busy();
        q_mod = 3; m_mod = 2;
        clear_counts();
        for (int i = 0; i < 64; i++) src[i] = 32'hC300_0000 + i;
        wr_reg(2'd0, 32'h0000_0040);
        wr_reg(2'd1, 32'h0001_0005);
        wr_reg(2'd2, 32'h0100_0200);
        wr_reg(2'd0, 32'h0000_0999);
        wr_reg(2'd1, 32'h0003_0003);
        wr_reg(2'd2, 32'h0000_0000);
        wait_idle("R10 busy cleared");
        check(addr_reg_o == 32'h54, "R10 addr write ignored", addr_reg_o, 32'h54);
        check(blk_reg_o == 32'h0001_0005, "R10 blk write ignored", blk_reg_o, 32'h0001_0005);
        check(ctrl_reg_o == 32'h0000_0200, "R10 ctrl write ignored", ctrl_reg_o, 32'h200);
        q_mod = 1; m_mod = 1;
    endtask

    task automatic test_same_cycle();
        int n = 0;
        clear_counts();
        wr_reg(2'd0, 32'h0000_0000);
        wr_reg(2'd1, 32'h0001_0003);
        wr_reg(2'd2, 32'h0100_0201);
        while (!(push_valid_o && push_ready_i && sink_cnt == 2) && n < 100) begin
            @(negedge clk);
            n++;
        end
        cfg_wr_i = 1'b1; cfg_sel_i = 2'd1; cfg_wdata_i = 32'h0009_0009;
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_sel_i = 2'd3;
        check(done_o && !ctrl_reg_o[24], "R7 done with busy clear", {done_o, ctrl_reg_o[24]}, 2'b10);
        check(blk_reg_o == 32'h0001_0003, "R10 write at finish ignored", blk_reg_o, 32'h0001_0003);
        wr_reg(2'd2, 32'h0100_0201);
        check(ctrl_reg_o[24], "R3 immediate restart", ctrl_reg_o, 32'h0100_0201);
        wait_idle("R6 restart completes");
        check(addr_reg_o == 32'h18, "R6 address after two runs", addr_reg_o, 32'h18);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i * 32'h0101;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_regs_no_start();
        test_m2p(32'h0000_0010, 32'h0002_0003, 1, 1);
        test_m2p(32'h0000_0080, 32'h0004_0001, 3, 2);
        test_p2m(32'h0000_0040, 32'h0001_0005, 1, 1);
        test_p2m(32'h0000_00A0, 32'h0003_0002, 2, 3);
        test_unknown();
        test_zero();
        test_write_busy();
        test_same_cycle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule